// File: doc/BRIEF.md
# Self-Test Pattern and Signature Unit

This block wraps a streaming datapath with built-in self-test logic. A diagnostic source produces a pseudo-random sequence, a programmed constant or an incrementing ramp. Each of four input ports can take either its live data or that diagnostic stream, chosen port by port. The datapath itself is represented by a one-stage placeholder that forms an I/Q pair from the four port values. A multiple-input signature register compacts every valid I/Q sample into a 32-bit checksum.

A programmable general timer ties everything together. Once software has written the mode, the port selects, the sync source and the interval, and has set the run bit, the timer counts the interval and pulses a one-cycle sync at terminal count. That pulse copies the final signature into a readable register, clears the signature register and, if so configured, reseeds the pattern source. Software can therefore compare the captured signature against a golden value interval after interval. A status field reports when four intervals have completed since the last configuration write, which is when the signature may be trusted.

Top module: `sst_top`

## Requirements
- R1: CTRL[1:0] selects the diagnostic value: 0 or 3 gives a 16-bit Fibonacci LFSR (feedback is the XOR of state bits 15, 13, 12 and 10, shifted in at bit 0, reseed value 16'hACE1), 1 gives the CONST register, 2 gives a ramp reseeded to 0. LFSR and ramp both advance once on every cycle with liveValid high.
- R2: For port k (0..3), CTRL[4+k]=1 routes the diagnostic value into the datapath and CTRL[4+k]=0 routes liveData[16k+15:16k].
- R3: One cycle after the ports are sampled, dataI equals port0+port2 and dataQ equals port1+port3 (modulo 2^16), and dataValid equals the liveValid of that cycle.
- R4: With CTRL[3] (run) set, a timer counts 0 up to the INTERVAL register and syncOut is high for the one cycle in which the count equals INTERVAL, so syncs repeat every INTERVAL+1 cycles; with run clear the count stays at 0 and syncOut stays low.
- R5: CTRL[2]=0 reseeds the pattern source on each timer sync; CTRL[2]=1 reseeds it on each cycle with extSync high instead. The reseeded value is used from the next cycle on.
- R6: The signature register steps as next = {sig[30:0],0} XOR (sig[31] ? 32'h04C11DB7 : 0) XOR {dataI,dataQ} on each cycle with dataValid high. On a sync the stepped value (including that cycle's sample) is copied to the capture register read at address 3, and the signature register restarts from zero.
- R7: Address 4 reads bit 0 = stable and bits 3:1 = completed syncs since the last configuration write, saturating at 4; stable is set exactly when the count is 4.
- R8: Addresses 0 (CTRL, 8 bits), 1 (CONST, 16 bits) and 2 (INTERVAL, 16 bits) read back what was written; a write to any of them clears the timer, the signature register and the sync count and reseeds the pattern source. Writes to addresses 3 to 7 change nothing, and addresses 5 to 7 read zero. After reset every readable value is zero.
- R9: The ramp wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| extSync | input | 1 | External sync event for the pattern source |
| liveData | input | 64 | Live data, four 16-bit ports, port k in bits 16k+15:16k |
| liveValid | input | 1 | Live data valid |
| dataI | output | 16 | Placeholder datapath I output |
| dataQ | output | 16 | Placeholder datapath Q output |
| dataValid | output | 1 | Datapath output valid |
| syncOut | output | 1 | One-cycle timer sync pulse |

## Verification
The hardest state to reach is the ramp wrap, which needs 65,536 valid cycles without any reseed; the stimulus selects the external sync source, holds extSync low and streams valid samples for that whole stretch with only port 0 on the diagnostic path, so the ramp appears directly on dataI. The saturation of the interval count and its clearing by a configuration write are reached by long timed runs followed by a write. A known signature is forced by an interval of zero, where every cycle is a sync, so one hand-computed sample lands in the capture register.

// File: rtl/sst_pkg.sv
package sst_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CONST    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_INTERVAL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SIG      = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 3'd4;

  typedef enum logic [1:0] {
    PAT_LFSR     = 2'd0,
    PAT_CONST    = 2'd1,
    PAT_RAMP     = 2'd2,
    PAT_LFSR_ALT = 2'd3
  } patMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgRestart;
    logic timerSync;
    logic patRestart;
  } strobes_t;

endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int PORTS    = 4,
  parameter int DATA_W   = 16,
  parameter int TIMER_W  = 16,
  parameter int REG_W    = 32,
  parameter int STABLE_N = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [REG_W-1:0]             regWdata,
  input  logic                         extSync,
  output patMode_e                     modeSel,
  output logic [PORTS-1:0]             portSel,
  output logic [DATA_W-1:0]            constVal,
  output logic [TIMER_W-1:0]           intervalVal,
  output logic [4+PORTS-1:0]           ctrlWord,
  output logic                         runOn,
  output logic                         stableFlag,
  output logic [$clog2(STABLE_N+1)-1:0] doneCnt,
  output strobes_t                     strobes
);

  localparam int CTRL_W = 4 + PORTS;
  localparam int CNT_W  = $clog2(STABLE_N + 1);
  localparam int MAX_A  = (CTRL_W > DATA_W) ? CTRL_W : DATA_W;
  localparam int USED_W = (MAX_A > TIMER_W) ? MAX_A : TIMER_W;

  logic               cfgWr;
  logic               syncSrcExt;
  logic               timerHit;
  logic [TIMER_W-1:0] timerQ;
  logic               unusedWdataHi;

  assign unusedWdataHi = ^regWdata[REG_W-1:USED_W];

  assign modeSel    = patMode_e'(ctrlWord[1:0]);
  assign syncSrcExt = ctrlWord[2];
  assign runOn      = ctrlWord[3];
  assign portSel    = ctrlWord[4 +: PORTS];

  assign cfgWr    = regWe && (regAddr <= ADDR_INTERVAL);
  assign timerHit = runOn && (timerQ == intervalVal);

  assign strobes.cfgRestart = cfgWr;
  assign strobes.timerSync  = timerHit;
  assign strobes.patRestart = cfgWr || (syncSrcExt ? extSync : timerHit);

  assign stableFlag = (doneCnt == CNT_W'(STABLE_N));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord    <= '0;
      constVal    <= '0;
      intervalVal <= '0;
      timerQ      <= '0;
      doneCnt     <= '0;
    end else begin
      if (cfgWr && regAddr == ADDR_CTRL)     ctrlWord    <= regWdata[CTRL_W-1:0];
      if (cfgWr && regAddr == ADDR_CONST)    constVal    <= regWdata[DATA_W-1:0];
      if (cfgWr && regAddr == ADDR_INTERVAL) intervalVal <= regWdata[TIMER_W-1:0];

      if (cfgWr || !runOn || timerHit) timerQ <= '0;
      else                             timerQ <= timerQ + 1'b1;

      if (cfgWr)                                          doneCnt <= '0;
      else if (timerHit && doneCnt < CNT_W'(STABLE_N))    doneCnt <= doneCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sst_dp.sv
module sst_dp
  import sst_pkg::*;
#(
  parameter int                      PORTS     = 4,
  parameter int                      DATA_W    = 16,
  parameter logic [DATA_W-1:0]       LFSR_MASK = 16'hB400,
  parameter logic [DATA_W-1:0]       LFSR_SEED = 16'hACE1,
  parameter logic [2*DATA_W-1:0]     MISR_POLY = 32'h04C11DB7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                strobes,
  input  patMode_e                modeSel,
  input  logic [PORTS-1:0]        portSel,
  input  logic [DATA_W-1:0]       constVal,
  input  logic [PORTS*DATA_W-1:0] liveData,
  input  logic                    liveValid,
  output logic [DATA_W-1:0]       dataI,
  output logic [DATA_W-1:0]       dataQ,
  output logic                    dataValid,
  output logic [2*DATA_W-1:0]     sigCapture
);

  localparam int SIG_W = 2 * DATA_W;

  logic [DATA_W-1:0] lfsrQ, rampQ, diagVal, sumI, sumQ;
  logic [DATA_W-1:0] portVal [PORTS];
  logic [SIG_W-1:0]  misrQ, misrStep;

  // Diagnostic source
  always_comb begin
    case (modeSel)
      PAT_CONST: diagVal = constVal;
      PAT_RAMP:  diagVal = rampQ;
      default:   diagVal = lfsrQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
      rampQ <= '0;
    end else if (strobes.patRestart) begin
      lfsrQ <= LFSR_SEED;
      rampQ <= '0;
    end else if (liveValid) begin
      lfsrQ <= {lfsrQ[DATA_W-2:0], ^(lfsrQ & LFSR_MASK)};
      rampQ <= rampQ + 1'b1;
    end
  end

  // Per-port input select
  for (genvar k = 0; k < PORTS; k++) begin : gPortMux
    assign portVal[k] = portSel[k] ? diagVal : liveData[k*DATA_W +: DATA_W];
  end

  // Placeholder datapath: even ports to I, odd ports to Q
  always_comb begin
    sumI = '0;
    sumQ = '0;
    for (int k = 0; k < PORTS; k++) begin
      if (k % 2 == 0) sumI = sumI + portVal[k];
      else            sumQ = sumQ + portVal[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataI     <= '0;
      dataQ     <= '0;
      dataValid <= 1'b0;
    end else begin
      dataI     <= sumI;
      dataQ     <= sumQ;
      dataValid <= liveValid;
    end
  end

  // Signature compaction
  always_comb begin
    misrStep = misrQ;
    if (dataValid)
      misrStep = {misrQ[SIG_W-2:0], 1'b0} ^ (misrQ[SIG_W-1] ? MISR_POLY : '0) ^ {dataI, dataQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      misrQ      <= '0;
      sigCapture <= '0;
    end else begin
      misrQ <= (strobes.cfgRestart || strobes.timerSync) ? '0 : misrStep;
      if (strobes.timerSync) sigCapture <= misrStep;
    end
  end

endmodule

// File: rtl/sst_top.sv
module sst_top
  import sst_pkg::*;
#(
  parameter int PORTS   = 4,
  parameter int DATA_W  = 16,
  parameter int TIMER_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [2*DATA_W-1:0]     regWdata,
  output logic [2*DATA_W-1:0]     regRdata,
  input  logic                    extSync,
  input  logic [PORTS*DATA_W-1:0] liveData,
  input  logic                    liveValid,
  output logic [DATA_W-1:0]       dataI,
  output logic [DATA_W-1:0]       dataQ,
  output logic                    dataValid,
  output logic                    syncOut
);

  localparam int REG_W    = 2 * DATA_W;
  localparam int CTRL_W   = 4 + PORTS;
  localparam int STABLE_N = 4;
  localparam int CNT_W    = $clog2(STABLE_N + 1);

  patMode_e           modeSel;
  logic [PORTS-1:0]   portSel;
  logic [DATA_W-1:0]  constVal;
  logic [TIMER_W-1:0] intervalVal;
  logic [CTRL_W-1:0]  ctrlWord;
  logic               runOn;
  logic               stableFlag;
  logic [CNT_W-1:0]   doneCnt;
  strobes_t           strobes;
  logic [REG_W-1:0]   sigCapture;

  sst_ctrl #(
    .PORTS(PORTS), .DATA_W(DATA_W), .TIMER_W(TIMER_W), .REG_W(REG_W), .STABLE_N(STABLE_N)
  ) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .extSync,
    .modeSel, .portSel, .constVal, .intervalVal, .ctrlWord,
    .runOn, .stableFlag, .doneCnt, .strobes
  );

  sst_dp #(
    .PORTS(PORTS), .DATA_W(DATA_W)
  ) u_dp (
    .clk, .rstN, .strobes, .modeSel, .portSel, .constVal,
    .liveData, .liveValid, .dataI, .dataQ, .dataValid, .sigCapture
  );

  assign syncOut = strobes.timerSync;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:     regRdata[CTRL_W-1:0]  = ctrlWord;
      ADDR_CONST:    regRdata[DATA_W-1:0]  = constVal;
      ADDR_INTERVAL: regRdata[TIMER_W-1:0] = intervalVal;
      ADDR_SIG:      regRdata              = sigCapture;
      ADDR_STATUS:   regRdata[CNT_W:0]     = {doneCnt, stableFlag};
      default:       regRdata              = '0;
    endcase
  end

endmodule

// File: rtl/sst_checks.sv
module sst_checks #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [2:0]         regAddr,
  input logic               liveValid,
  input logic               dataValid,
  input logic               syncOut,
  input logic               runOn,
  input logic               stableFlag,
  input logic [TIMER_W-1:0] intervalVal
);

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    liveValid |=> dataValid);

  a_r3_invalid_follows: assert property (@(posedge clk) disable iff (!rstN)
    !liveValid |=> !dataValid);

  a_r4_sync_gap: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && runOn && intervalVal != '0 && !regWe) |=> !syncOut);

  a_r8_cfg_clears_stable: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr <= 3'd2) |=> !stableFlag);

  a_r7_stable_after_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stableFlag) |-> $past(syncOut));

  a_r7_stable_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stableFlag && !(regWe && regAddr <= 3'd2)) |=> stableFlag);

endmodule

bind sst_top sst_checks #(.TIMER_W(TIMER_W)) u_checks (
  .clk, .rstN, .regWe, .regAddr, .liveValid, .dataValid,
  .syncOut, .runOn, .stableFlag, .intervalVal
);

// File: tb/tb_sst_top.sv
`timescale 1ns/1ps
module tb_sst_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        extSync;
  logic [63:0] liveData;
  logic        liveValid;
  logic [15:0] dataI, dataQ;
  logic        dataValid;
  logic        syncOut;

  always #5 clk = ~clk;

  sst_top dut (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata, .extSync,
    .liveData, .liveValid, .dataI, .dataQ, .dataValid, .syncOut
  );

  int checks = 0;
  int fails  = 0;
  string phaseTag = "R8";

  // Reference model state
  logic [7:0]  mCtrl;
  logic [15:0] mConst, mInterval, mTimer, mLfsr, mRamp, mI, mQ;
  logic [31:0] mMisr, mCap;
  logic        mV;
  int          mCnt;

  function automatic logic [15:0] lfsrNext(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [31:0] misrNext(input logic [31:0] m, input logic [31:0] d);
    return {m[30:0], 1'b0} ^ (m[31] ? 32'h04C11DB7 : 32'h0) ^ d;
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {24'h0, mCtrl};
      3'd1: return {16'h0, mConst};
      3'd2: return {16'h0, mInterval};
      3'd3: return mCap;
      3'd4: return {28'h0, 3'(mCnt), mCnt == 4};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [2:0] a);
    if (a == 3'd3) return "R6";
    if (a == 3'd4) return "R7";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic we, input logic [2:0] a, input logic [31:0] wd,
                      input logic [63:0] live, input logic lv, input logic ext);
    logic        sync, cfgWr, patR;
    logic [15:0] diag, nI, nQ;
    logic [15:0] p [4];
    logic [31:0] ms;
    regWe = we; regAddr = a; regWdata = wd; liveData = live; liveValid = lv; extSync = ext;
    #1;
    sync = mCtrl[3] && (mTimer == mInterval);
    check(dataI == mI, {"R3 ", phaseTag}, "dataI", 32'(dataI), 32'(mI));
    check(dataQ == mQ, {"R3 ", phaseTag}, "dataQ", 32'(dataQ), 32'(mQ));
    check(dataValid == mV, "R3", "dataValid", 32'(dataValid), 32'(mV));
    check(syncOut == sync, "R4", "syncOut", 32'(syncOut), 32'(sync));
    check(regRdata == expRead(a), readTag(a), "regRdata", regRdata, expRead(a));
    // model step for the coming edge
    cfgWr = we && (a <= 3'd2);
    patR  = cfgWr || (mCtrl[2] ? ext : sync);
    case (mCtrl[1:0])
      2'd1:    diag = mConst;
      2'd2:    diag = mRamp;
      default: diag = mLfsr;
    endcase
    for (int k = 0; k < 4; k++) p[k] = mCtrl[4+k] ? diag : live[16*k +: 16];
    nI = p[0] + p[2];
    nQ = p[1] + p[3];
    ms = mV ? misrNext(mMisr, {mI, mQ}) : mMisr;
    if (sync) mCap = ms;
    mMisr = (cfgWr || sync) ? 32'h0 : ms;
    if (patR) begin
      mLfsr = 16'hACE1; mRamp = 16'h0;
    end else if (lv) begin
      mLfsr = lfsrNext(mLfsr); mRamp = mRamp + 16'd1;
    end
    if (cfgWr || !mCtrl[3] || sync) mTimer = 16'h0;
    else                            mTimer = mTimer + 16'd1;
    if (cfgWr)                   mCnt = 0;
    else if (sync && mCnt < 4)   mCnt = mCnt + 1;
    if (we && a == 3'd0) mCtrl     = wd[7:0];
    if (we && a == 3'd1) mConst    = wd[15:0];
    if (we && a == 3'd2) mInterval = wd[15:0];
    mI = nI; mQ = nQ; mV = lv;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] wd);
    tick(1'b1, a, wd, 64'h0, 1'b0, 1'b0);
  endtask

  task automatic rnd(input int n, input int extPct);
    for (int i = 0; i < n; i++)
      tick(1'b0, 3'($urandom % 8), 32'h0, {$urandom, $urandom},
           ($urandom % 4) != 0, ($urandom % 100) < extPct);
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regWe = 1'b0; regAddr = a;
    #1;
    check(regRdata == exp, tag, "readback", regRdata, exp);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int syncSeen;
    void'($urandom(32'd20240607));
    mCtrl = '0; mConst = '0; mInterval = '0; mTimer = '0; mLfsr = 16'hACE1; mRamp = '0;
    mI = '0; mQ = '0; mMisr = '0; mCap = '0; mV = 1'b0; mCnt = 0;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; extSync = 1'b0;
    liveData = '0; liveValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state, R8
    for (int a = 0; a < 8; a++) tick(1'b0, 3'(a), 32'h0, 64'h0, 1'b0, 1'b0);
    readCheck(3'd3, 32'h0, "R8 reset signature");

    // R1 constant mode on all ports, interval 7
    phaseTag = "R1";
    wr(3'd1, 32'h1234);
    wr(3'd2, 32'd7);
    wr(3'd0, 32'hF9);
    rnd(30, 10);
    readCheck(3'd4, 32'h6, "R7 three syncs");
    rnd(50, 10);
    readCheck(3'd4, 32'h9, "R7 saturated stable");

    // R8 write to read-only / unused addresses ignored
    wr(3'd6, 32'hFFFF_FFFF);
    readCheck(3'd0, 32'hF9, "R8 ctrl kept");
    readCheck(3'd1, 32'h1234, "R8 const kept");
    readCheck(3'd2, 32'h7, "R8 interval kept");
    readCheck(3'd4, 32'h9, "R8 status kept");
    wr(3'd3, 32'hDEAD_BEEF);
    readCheck(3'd5, 32'h0, "R8 unused reads zero");

    // R2 LFSR on ports 0 and 2, live on 1 and 3
    phaseTag = "R2";
    wr(3'd0, 32'h58);
    readCheck(3'd4, 32'h0, "R8 cfg write clears status");
    readCheck(3'd0, 32'h58, "R8 ctrl readback");
    rnd(200, 10);
    wr(3'd0, 32'hFB);
    rnd(100, 10);

    // R4 sync period with interval 3
    phaseTag = "R4";
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h08);
    syncSeen = 0;
    for (int k = 1; k <= 40; k++) begin
      rnd(1, 0);
      if (syncOut) syncSeen++;
    end
    check(syncSeen == 10, "R4", "sync count", 32'(syncSeen), 32'd10);
    wr(3'd0, 32'h00);
    rnd(20, 0);

    // R5 ramp with external sync source
    phaseTag = "R5";
    wr(3'd0, 32'h3E);
    rnd(300, 8);
    wr(3'd0, 32'hA4);
    rnd(200, 15);

    // R6 known signature with a sync every cycle
    phaseTag = "R6";
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h08);
    for (int i = 0; i < 5; i++) tick(1'b0, 3'd3, 32'h0, 64'h0, 1'b0, 1'b0);
    readCheck(3'd3, 32'h0, "R6 empty signature");
    tick(1'b0, 3'd3, 32'h0, 64'h0004_0003_0002_0001, 1'b1, 1'b0);
    tick(1'b0, 3'd3, 32'h0, 64'h0, 1'b0, 1'b0);
    readCheck(3'd3, 32'h0004_0006, "R6 single sample signature");
    wr(3'd2, 32'd5);
    rnd(200, 0);

    // R9 ramp wrap, port 0 only, external sync held low
    phaseTag = "R9";
    wr(3'd0, 32'h16);
    for (int j = 1; j <= 65537; j++) begin
      tick(1'b0, 3'd0, 32'h0, 64'h0, 1'b1, 1'b0);
      if (j == 65536) check(dataI == 16'hFFFF, "R9", "ramp top", 32'(dataI), 32'hFFFF);
      if (j == 65537) check(dataI == 16'h0000, "R9", "ramp wrap", 32'(dataI), 32'h0);
    end

    // Random mix including configuration writes, R8
    phaseTag = "R8";
    wr(3'd2, 32'd9);
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 40) == 0)
        tick(1'b1, 3'($urandom % 8), {16'h0, 16'($urandom % 32)} | ($urandom & 32'hFF),
             {$urandom, $urandom}, 1'b1, 1'b0);
      else
        rnd(1, 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule